// File: doc/BRIEF.md
# Filtered Peak Crossing Identifier

This block takes one digitised calorimeter tower sample on every bunch-crossing clock. It turns the stream into a per-crossing energy value, so that each pulse, which spreads over several crossings, is credited to exactly one of them. A five-tap weighted sum smooths the samples. A local-maximum test then marks the crossing where the smoothed pulse is highest. Only that crossing carries a non-zero energy word. Every other crossing reports zero.

The weights are loaded one at a time through a small write port. The energy at a peak is divided by a programmable power of two and clamped to the output width. It is cleared when it falls below a programmable noise floor. The latency is fixed, so downstream logic can align the output with the crossing number by a constant offset. All pipeline state and all weights clear to zero on reset.

Top module: `fir_peak_bcid`

## Requirements
- R1: While `rst_n` is low, and immediately after it is released, `etOut` is 0 and `etValid` is 0. All weights reset to 0.
- R2: The filtered value for crossing n is F(n) = sum over k = 0..4 of w[k]·x(n−k). x(n) is the sample captured at crossing n, and w[k] is the weight written with `cfgAddr` = k. So weight 0 multiplies the newest sample.
- R3: A crossing c is a peak exactly when F(c) > F(c−1) and F(c) ≥ F(c+1). For a flat-topped pulse, only the first crossing of the plateau is reported.
- R4: `etOut` is never non-zero on two consecutive clock cycles.
- R5: At a peak, the reported value is F(c) shifted right by `shiftAmt` bits. If the result exceeds 255 it is replaced by 255.
- R6: A shifted value strictly below `noiseThresh` is reported as 0. A value equal to the threshold is reported unchanged.
- R7: The energy for peak crossing c appears on `etOut` after the clock edge that captures sample c+3. `etValid` rises after the fourth edge following reset release and stays high.
- R8: A write with `cfgAddr` of 5, 6 or 7 changes no weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock, one sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleIn | input | 10 | Unsigned ADC sample for the current crossing |
| cfgWrEn | input | 1 | Weight write strobe |
| cfgAddr | input | 3 | Index of the weight to write |
| cfgData | input | 4 | Unsigned weight value |
| shiftAmt | input | 3 | Right-shift applied to the peak value |
| noiseThresh | input | 8 | Lowest reported energy; smaller values become 0 |
| etOut | output | 8 | Energy word, non-zero only at a peak crossing |
| etValid | output | 1 | High once the pipeline holds real crossings |

## Verification
A single-sample impulse is sent with ascending weights and then with descending weights. The filter shape then puts the peak at opposite ends of the five-crossing window, and the arrival cycle shows both the weight order and the fixed latency. A flat-topped pulse probes the tie rule: a symmetric comparison would report either nothing or several crossings. Full-scale samples with the largest weights exercise clamping. An impulse scaled to land exactly on the noise floor, and then one step below it, separates strict from inclusive comparison. A long random stream, with weights, shift and floor changed mid-run, is compared on every cycle against a behavioural model. During that stream, writes to unused addresses must leave the output unchanged.

// File: rtl/bcid_pkg.sv
package bcid_pkg;

  // number of filter taps (window length in crossings)
  localparam int unsigned BCID_TAPS = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic [BCID_TAPS-1:0] tapWe;      // one-hot weight write enable
    logic                 markValid;  // output stage holds a real crossing
  } bcidStrobes_t;

endpackage

// File: rtl/bcid_ctrl.sv
module bcid_ctrl
  import bcid_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned PIPE_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  output bcidStrobes_t      strb
);

  localparam int unsigned FILL_W = $clog2(PIPE_LAT + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(PIPE_LAT);

  logic [FILL_W-1:0] fillCnt;

  // count edges since reset until the output stage sees real data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fillCnt <= '0;
    end else if (fillCnt != FILL_MAX) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  // decode weight writes; out-of-range addresses select nothing
  for (genvar i = 0; i < BCID_TAPS; i++) begin : g_dec
    assign strb.tapWe[i] = cfgWrEn && (cfgAddr == ADDR_W'(i));
  end

  assign strb.markValid = (fillCnt == FILL_MAX);

  // R7
  fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fillCnt != '0) |=> (fillCnt != '0));

  // R8
  tap_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb.tapWe));

endmodule

// File: rtl/bcid_datapath.sv
module bcid_datapath
  import bcid_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned COEF_W   = 4,
  parameter int unsigned ET_W     = 8,
  parameter int unsigned SHIFT_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [COEF_W-1:0]   cfgData,
  input  logic [SHIFT_W-1:0]  shiftAmt,
  input  logic [ET_W-1:0]     noiseThresh,
  input  bcidStrobes_t        strb,
  output logic [ET_W-1:0]     etOut,
  output logic                etValid
);

  localparam int unsigned FIR_W = SAMPLE_W + COEF_W + $clog2(BCID_TAPS);

  logic [SAMPLE_W-1:0] winReg [BCID_TAPS];
  logic [COEF_W-1:0]   tapReg [BCID_TAPS];
  logic [FIR_W-1:0]    prodVal [BCID_TAPS];
  logic [FIR_W-1:0]    firSum;
  logic [FIR_W-1:0]    firQ, firD1, firD2;
  logic                isPeak;
  logic [FIR_W-1:0]    scaled;
  logic [ET_W-1:0]     clamped, gated;

  // sample window and weights
  for (genvar i = 0; i < BCID_TAPS; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tapReg[i] <= '0;
      end else if (strb.tapWe[i]) begin
        tapReg[i] <= cfgData;
      end
    end

    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) winReg[0] <= '0;
        else        winReg[0] <= sampleIn;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) winReg[i] <= '0;
        else        winReg[i] <= winReg[i-1];
      end
    end

    assign prodVal[i] = FIR_W'(winReg[i]) * FIR_W'(tapReg[i]);
  end

  always_comb begin
    firSum = '0;
    for (int k = 0; k < BCID_TAPS; k++) begin
      firSum = firSum + prodVal[k];
    end
  end

  // filtered history: newest, centre, oldest
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      firQ  <= '0;
      firD1 <= '0;
      firD2 <= '0;
    end else begin
      firQ  <= firSum;
      firD1 <= firQ;
      firD2 <= firD1;
    end
  end

  // strict rise on the left, non-strict fall on the right
  assign isPeak = (firD1 > firD2) && (firD1 >= firQ);

  assign scaled  = firD1 >> shiftAmt;
  assign clamped = (|(scaled >> ET_W)) ? {ET_W{1'b1}} : scaled[ET_W-1:0];
  assign gated   = (clamped < noiseThresh) ? '0 : clamped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      etOut   <= '0;
      etValid <= 1'b0;
    end else begin
      etOut   <= isPeak ? gated : '0;
      etValid <= strb.markValid;
    end
  end

  // R4
  no_consec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (etOut != '0) |=> (etOut == '0));

  // R6
  thresh_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (etOut != '0) |-> (etOut >= $past(noiseThresh)));

  // R3
  rising_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (etOut != '0) |-> ($past(firD1) > $past(firD2)));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    etValid |=> etValid);

endmodule

// File: rtl/fir_peak_bcid.sv
module fir_peak_bcid
  import bcid_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned COEF_W   = 4,
  parameter int unsigned ET_W     = 8,
  parameter int unsigned SHIFT_W  = 3,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [COEF_W-1:0]   cfgData,
  input  logic [SHIFT_W-1:0]  shiftAmt,
  input  logic [ET_W-1:0]     noiseThresh,
  output logic [ET_W-1:0]     etOut,
  output logic                etValid
);

  localparam int unsigned PIPE_LAT = 3;

  bcidStrobes_t strb;

  bcid_ctrl #(
    .ADDR_W  (ADDR_W),
    .PIPE_LAT(PIPE_LAT)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr),
    .strb   (strb)
  );

  bcid_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .COEF_W  (COEF_W),
    .ET_W    (ET_W),
    .SHIFT_W (SHIFT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleIn   (sampleIn),
    .cfgData    (cfgData),
    .shiftAmt   (shiftAmt),
    .noiseThresh(noiseThresh),
    .strb       (strb),
    .etOut      (etOut),
    .etValid    (etValid)
  );

endmodule

// File: tb/fir_peak_bcid_bench.sv
module fir_peak_bcid_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] sampleIn = '0;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [3:0] cfgData = '0;
  logic [2:0] shiftAmt = '0;
  logic [7:0] noiseThresh = '0;
  logic [7:0] etOut;
  logic       etValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fir_peak_bcid u_fir_peak_bcid (
    .clk(clk), .rst_n(rst_n), .sampleIn(sampleIn), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .shiftAmt(shiftAmt),
    .noiseThresh(noiseThresh), .etOut(etOut), .etValid(etValid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int cyc = 0;
  int xq[$];
  int fq[$];
  int mTap[5];
  int fillEdges = 0;
  int expEt = 0;
  int expValid = 0;

  always @(posedge clk) begin
    int nf, s;
    cyc++;
    if (!rst_n) begin
      xq = {0, 0, 0, 0, 0};
      fq = {0, 0, 0};
      foreach (mTap[i]) mTap[i] = 0;
      fillEdges = 0;
      expEt = 0;
      expValid = 0;
    end else begin
      nf = 0;
      for (int k = 0; k < 5; k++) nf += mTap[k] * xq[k];
      s = 0;
      if (fq[1] > fq[2] && fq[1] >= fq[0]) begin
        s = fq[1] >> shiftAmt;
        if (s > 255) s = 255;
        if (s < int'(noiseThresh)) s = 0;
      end
      expEt = s;
      fillEdges++;
      expValid = (fillEdges >= 4) ? 1 : 0;
      fq.push_front(nf);  void'(fq.pop_back());
      xq.push_front(int'(sampleIn)); void'(xq.pop_back());
      if (cfgWrEn && cfgAddr < 5) mTap[cfgAddr] = int'(cfgData);
    end
  end

  // per-cycle comparison and window statistics
  bit winOn = 1'b0;
  int nzCount = 0, maxEt = 0, firstNz = -1;
  bit prevNz = 1'b0;

  always @(negedge clk) begin
    check("R3", int'(etOut), expEt);
    check("R7", int'(etValid), expValid);
    if (rst_n && prevNz && etOut != 0) check("R4", int'(etOut), 0);
    prevNz = (etOut != 0);
    if (winOn && etOut != 0) begin
      nzCount++;
      if (etOut > maxEt) maxEt = etOut;
      if (firstNz < 0) firstNz = cyc;
    end
  end

  task automatic clearWin();
    nzCount = 0; maxEt = 0; firstNz = -1; winOn = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); sampleIn = '0; end
  endtask

  task automatic cfgWrite(input int a, input int d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 3'(a); cfgData = 4'(d);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setTaps(input int t0, t1, t2, t3, t4);
    cfgWrite(0, t0); cfgWrite(1, t1); cfgWrite(2, t2);
    cfgWrite(3, t3); cfgWrite(4, t4);
  endtask

  // impulse of height h; returns delay from capture edge to first output
  task automatic impulse(input int h, output int delay);
    int capEdge;
    clearWin();
    @(negedge clk);
    sampleIn = 10'(h);
    capEdge = cyc + 1;
    idle(12);
    winOn = 1'b0;
    delay = (firstNz < 0) ? -1 : firstNz - capEdge;
  endtask

  initial begin
    int d;
    // R1 during and just after reset
    repeat (3) @(negedge clk);
    check("R1", int'(etOut), 0);
    check("R1", int'(etValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(etValid), 0);

    // R2 weight order: ascending puts peak on the newest tap's far end
    setTaps(1, 2, 3, 4, 5);
    idle(8);
    impulse(40, d);
    check("R2", maxEt, 200);
    check("R2", d, 7);
    check("R3", nzCount, 1);

    // R7 descending weights peak at the impulse crossing
    setTaps(5, 4, 3, 2, 1);
    idle(8);
    impulse(40, d);
    check("R7", d, 3);
    check("R7", int'(etValid), 1);

    // R3 flat-topped pulse: one report at the plateau start
    setTaps(1, 2, 3, 2, 1);
    shiftAmt = 3'd1;
    idle(8);
    clearWin();
    repeat (10) begin @(negedge clk); sampleIn = 10'd50; end
    idle(12);
    winOn = 1'b0;
    check("R3", nzCount, 1);
    check("R5", maxEt, 225);

    // R5 clamp on full-scale input
    setTaps(15, 15, 15, 15, 15);
    shiftAmt = 3'd0;
    idle(8);
    clearWin();
    repeat (3) begin @(negedge clk); sampleIn = 10'd1023; end
    idle(12);
    winOn = 1'b0;
    check("R5", maxEt, 255);

    // R5/R6 shift and noise floor boundary
    setTaps(1, 2, 3, 4, 5);
    shiftAmt = 3'd2;
    noiseThresh = 8'd50;
    idle(8);
    impulse(40, d);
    check("R6", maxEt, 50);
    check("R5", maxEt, 50);
    noiseThresh = 8'd51;
    impulse(40, d);
    check("R6", nzCount, 0);
    noiseThresh = 8'd0;

    // R8 writes to unused addresses leave weights alone
    cfgWrite(5, 15); cfgWrite(6, 0); cfgWrite(7, 9);
    idle(8);
    impulse(40, d);
    check("R8", maxEt, 50);
    check("R8", d, 7);

    // random stream with mid-run reconfiguration
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      sampleIn = 10'($urandom_range(0, 1023));
      if (n % 97 == 50) begin
        cfgWrEn = 1'b1;
        cfgAddr = 3'($urandom_range(0, 7));
        cfgData = 4'($urandom_range(0, 15));
      end else begin
        cfgWrEn = 1'b0;
      end
      if (n % 131 == 70) shiftAmt = 3'($urandom_range(0, 7));
      if (n % 151 == 90) noiseThresh = 8'($urandom_range(0, 40));
    end
    cfgWrEn = 1'b0;
    idle(10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule